// File: doc/BRIEF.md
# Serial Receive Port with Byte-Wide Registers

This block is an asynchronous serial receiver behind a small register file that is read and written one byte at a time. Software programs a divisor and a speed-range bit, enables the port, and then takes in frames with eight or nine data bits. Every frame is sent least significant bit first, has one start bit and one stop bit, and is checked against a three-sample majority vote taken at the middle of each bit.

Completed frames go into a two-entry queue. A "data ready" flag stays set while the queue holds anything, and it drives an interrupt line through a mask bit. A low stop bit is reported as a framing error. A frame that arrives when the queue is full is reported as an overrun. After an overrun the receiver stops until software drops the continuous-receive enable and sets it again, and that action also clears both error flags.

Top module: `serial_rx_port`

## Requirements
- R1: After reset every register reads 0x00. The address map is: 0 = status/control, 1 = receive data, 2 = divisor, 3 = mode. In the status register, bit 7 is port enable, bit 6 is nine-bit mode, bit 5 is single-receive enable, bit 4 is continuous enable, bit 3 is address-detect enable, bit 2 is framing error (read-only), bit 1 is overrun (read-only) and bit 0 is the received ninth bit (read-only). In the mode register, bit 0 is high speed, bit 1 is synchronous mode, bit 2 is interrupt enable and bit 7 is data ready (read-only).
- R2: Frames are received only while port enable and continuous enable are both 1 and synchronous mode is 0. A frame sent while any of these does not hold leaves data ready at 0.
- R3: One bit lasts (divisor+1)×16 clocks when high speed is 1, and (divisor+1)×64 clocks otherwise. Data bits arrive LSB first, and the byte read from address 1 equals the byte sent.
- R4: When nine-bit mode is set, the ninth data bit received appears in status bit 0 and the lower eight bits appear at address 1.
- R5: Data ready is 1 exactly while the queue is not empty. The interrupt output is data ready AND interrupt enable.
- R6: The queue holds two frames, which are read out in arrival order. Each read of address 1 removes one frame.
- R7: A frame that completes while the queue is full sets overrun and is discarded. No further frames are taken in until continuous enable is cleared and then set again.
- R8: Writing continuous enable to 0 clears both the framing error and the overrun flag.
- R9: A stop bit sampled low sets the framing error. The flag is rewritten when each frame is accepted, and reading the registers does not clear it.
- R10: A low pulse on the line that is gone by the middle of the start bit does not produce a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRd | input | 1 | Read strobe; a read of address 1 removes one frame from the queue |
| regRdData | output | 8 | Read data for the current address (combinational) |
| rxLine | input | 1 | Serial input; idles high |
| rxIrq | output | 1 | Interrupt: data ready AND interrupt enable |

## Verification
A received frame becomes visible about 2 to 3 clocks after the third sample of the stop bit. That sample comes about ten clocks into the stop bit, counting the two-stage input synchronizer and the vote register. The bench therefore reads results only after the whole stop bit has been sent plus four idle clocks. Register reads are combinational: the bench samples them 2 ns after the negative edge on which the address was set, and a read of address 1 removes its frame at the next rising edge. Status, flag and interrupt values are compared in the cycle after the write or read that changed them.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DIV_W = 8;

  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_MODE = 2'd3;

  typedef struct packed {
    logic             enable;
    logic             nineBit;
    logic             highSpeed;
    logic [DIV_W-1:0] divisor;
  } rxCfg_t;

  typedef struct packed {
    logic shift;
    logic bitVal;
    logic done;
    logic stopOk;
  } rxStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  rxCfg_t    cfg,
  input  logic      rxLine,
  output rxStrobe_t strobe
);
  localparam int CNT_W = DIV_W + 7;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   line;
  rxState_t               state;
  logic [CNT_W-1:0]       cnt;
  logic [3:0]             bitIdx;
  logic                   s0, s1;
  logic [CNT_W-1:0]       divExt, bitLen, half, lastCnt;
  logic                   atS0, atS1, atVote, vote;
  logic [3:0]             lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign line = syncQ[SYNC_STAGES-1];

  always_comb begin
    divExt  = CNT_W'(cfg.divisor) + CNT_W'(1);
    bitLen  = cfg.highSpeed ? (divExt << 4) : (divExt << 6);
    half    = bitLen >> 1;
    lastCnt = bitLen - CNT_W'(1);
    atS0    = (cnt == half - CNT_W'(1));
    atS1    = (cnt == half);
    atVote  = (cnt == half + CNT_W'(1));
    vote    = (s0 & s1) | (s0 & line) | (s1 & line);
    lastBit = cfg.nineBit ? 4'd8 : 4'd7;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      s0     <= 1'b1;
      s1     <= 1'b1;
    end else if (!cfg.enable) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (state == ST_IDLE) begin
      cnt <= '0;
      if (!line) state <= ST_START;
    end else begin
      if (atS0) s0 <= line;
      if (atS1) s1 <= line;
      cnt <= (cnt == lastCnt) ? '0 : cnt + CNT_W'(1);
      case (state)
        ST_START: begin
          if (atVote && vote) state <= ST_IDLE;
          else if (cnt == lastCnt) begin
            state  <= ST_DATA;
            bitIdx <= '0;
          end
        end
        ST_DATA: begin
          if (cnt == lastCnt) begin
            if (bitIdx == lastBit) state <= ST_STOP;
            else bitIdx <= bitIdx + 4'd1;
          end
        end
        ST_STOP: if (atVote) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.shift  = cfg.enable && (state == ST_DATA) && atVote;
    strobe.bitVal = vote;
    strobe.done   = cfg.enable && (state == ST_STOP) && atVote;
    strobe.stopOk = vote;
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shift && strobe.done));

  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> (state == ST_IDLE));

endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  input  logic       regRd,
  input  rxStrobe_t  strobe,
  output rxCfg_t     cfg,
  output logic [7:0] regRdData,
  output logic       rxIrq
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic portEn, nineBit, singleEn, contEn, addrDetEn, frameErr, overrun;
  logic highSpeed, syncMode, irqEn;
  logic [DIV_W-1:0] divisor;
  logic [8:0] shiftReg, frameWord;
  logic [8:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic full, empty, push, pop, drop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full      = (count == CNT_W'(FIFO_DEPTH));
  assign empty     = (count == '0);
  assign push      = strobe.done && !full;
  assign drop      = strobe.done && full;
  assign pop       = regRd && (regAddr == ADDR_DATA) && !empty;
  assign frameWord = nineBit ? shiftReg : {1'b0, shiftReg[8:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shift) shiftReg <= {strobe.bitVal, shiftReg[8:1]};
  end

  for (genvar e = 0; e < FIFO_DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mem[e] <= '0;
      else if (push && wrPtr == PTR_W'(e)) mem[e] <= frameWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {portEn, nineBit, singleEn, contEn, addrDetEn} <= '0;
      {highSpeed, syncMode, irqEn} <= '0;
      divisor <= '0;
    end else if (regWr) begin
      case (regAddr)
        ADDR_STAT: {portEn, nineBit, singleEn, contEn, addrDetEn} <= regWrData[7:3];
        ADDR_DIV:  divisor <= regWrData;
        ADDR_MODE: {irqEn, syncMode, highSpeed} <= regWrData[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else if (!contEn) begin
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (push) frameErr <= !strobe.stopOk;
      if (drop) overrun  <= 1'b1;
    end
  end

  always_comb begin
    cfg.enable    = portEn && !syncMode && contEn && !overrun;
    cfg.nineBit   = nineBit;
    cfg.highSpeed = highSpeed;
    cfg.divisor   = divisor;
  end

  always_comb begin
    case (regAddr)
      ADDR_STAT: regRdData = {portEn, nineBit, singleEn, contEn, addrDetEn,
                              frameErr, overrun, !empty && mem[rdPtr][8]};
      ADDR_DATA: regRdData = mem[rdPtr][7:0];
      ADDR_DIV:  regRdData = divisor;
      default:   regRdData = {!empty, 4'b0, irqEn, syncMode, highSpeed};
    endcase
  end

  assign rxIrq = !empty && irqEn;

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(FIFO_DEPTH));

  p_drop_sets_overrun_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.done && full && contEn) |=> overrun);

  p_cont_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !contEn |=> (!overrun && !frameErr));

  p_last_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && count == CNT_W'(1)) |=> !rxIrq);

endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import serial_rx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  input  logic       regRd,
  output logic [7:0] regRdData,
  input  logic       rxLine,
  output logic       rxIrq
);
  rxCfg_t    cfg;
  rxStrobe_t strobe;

  serial_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .rxLine(rxLine), .strobe(strobe)
  );

  serial_rx_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .strobe(strobe), .cfg(cfg),
    .regRdData(regRdData), .rxIrq(rxIrq)
  );
endmodule

// File: tb/serial_rx_port_test.sv
`timescale 1ns/1ps
module serial_rx_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRd = 1'b0;
  logic [7:0] regRdData;
  logic       rxLine = 1'b1;
  logic       rxIrq;
  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  serial_rx_port uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRd(regRd), .regRdData(regRdData),
    .rxLine(rxLine), .rxIrq(rxIrq)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #2 d = regRdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic sendFrame(int nBits, logic [8:0] val, logic stopBit, int per);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      rxLine = val[i];
      repeat (per) @(negedge clk);
    end
    rxLine = stopBit;
    repeat (per) @(negedge clk);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic expectFrame(string tag, int stat, int data);
    logic [7:0] v;
    rdReg(2'd0, v); check({tag, " status"}, v, stat);
    rdReg(2'd1, v); check({tag, " data"}, v, data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL all: watchdog got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rdReg(2'(a), v); check("R1 reset value", v, 0);
    end
    check("R1 irq at reset", rxIrq, 0);

    // R3/R5 byte sweep at 16 clocks per bit
    wrReg(2'd2, 8'd0);
    wrReg(2'd3, 8'h05);
    wrReg(2'd0, 8'h90);
    for (int i = 0; i < 18; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 73 + 5) & 255);
      sendFrame(8, {1'b0, b}, 1'b1, 16);
      check("R5 irq on frame", rxIrq, 1);
      rdReg(2'd3, v); check("R5 ready flag", v, 8'h85);
      expectFrame("R3 byte sweep", 8'h90, b);
      check("R5 irq after drain", rxIrq, 0);
    end

    // R3 other bit lengths: 32 and 64 clocks
    wrReg(2'd2, 8'd1);
    sendFrame(8, 9'h0C3, 1'b1, 32);
    expectFrame("R3 divisor 1 high speed", 8'h90, 8'hC3);
    wrReg(2'd2, 8'd0);
    wrReg(2'd3, 8'h04);
    sendFrame(8, 9'h05A, 1'b1, 64);
    expectFrame("R3 divisor 0 low speed", 8'h90, 8'h5A);
    wrReg(2'd3, 8'h05);

    // R4 nine-bit mode
    wrReg(2'd0, 8'hD0);
    for (int i = 0; i < 4; i++) begin
      logic [8:0] w;
      w = 9'((i * 181 + 300) & 511);
      sendFrame(9, w, 1'b1, 16);
      expectFrame("R4 nine-bit", 8'hD0 | w[8], w[7:0]);
    end
    wrReg(2'd0, 8'h90);

    // R6 two-entry queue order
    sendFrame(8, 9'h011, 1'b1, 16);
    sendFrame(8, 9'h022, 1'b1, 16);
    rdReg(2'd1, v); check("R6 first out", v, 8'h11);
    rdReg(2'd3, v); check("R6 still ready", v, 8'h85);
    rdReg(2'd1, v); check("R6 second out", v, 8'h22);
    rdReg(2'd3, v); check("R6 empty", v, 8'h05);

    // R7 overrun and stall, R8 clear
    sendFrame(8, 9'h0A1, 1'b1, 16);
    sendFrame(8, 9'h0B2, 1'b1, 16);
    sendFrame(8, 9'h0C3, 1'b1, 16);
    rdReg(2'd0, v); check("R7 overrun set", v, 8'h92);
    sendFrame(8, 9'h0D4, 1'b1, 16);
    rdReg(2'd1, v); check("R7 kept first", v, 8'hA1);
    rdReg(2'd1, v); check("R7 kept second", v, 8'hB2);
    rdReg(2'd3, v); check("R7 dropped frames", v, 8'h05);
    sendFrame(8, 9'h0E5, 1'b1, 16);
    rdReg(2'd3, v); check("R7 stalled", v, 8'h05);
    wrReg(2'd0, 8'h80);
    rdReg(2'd0, v); check("R8 overrun cleared", v, 8'h80);
    wrReg(2'd0, 8'h90);
    sendFrame(8, 9'h0E6, 1'b1, 16);
    expectFrame("R7 resumed", 8'h90, 8'hE6);

    // R9 framing error
    sendFrame(8, 9'h03C, 1'b0, 16);
    expectFrame("R9 framing error", 8'h94, 8'h3C);
    rdReg(2'd0, v); check("R9 kept after read", v, 8'h94);
    sendFrame(8, 9'h011, 1'b1, 16);
    expectFrame("R9 updated by good frame", 8'h90, 8'h11);
    sendFrame(8, 9'h077, 1'b0, 16);
    rdReg(2'd1, v);
    wrReg(2'd0, 8'h80);
    rdReg(2'd0, v); check("R8 framing cleared", v, 8'h80);
    wrReg(2'd0, 8'h90);

    // R2 gating
    wrReg(2'd0, 8'h10);
    sendFrame(8, 9'h055, 1'b1, 16);
    rdReg(2'd3, v); check("R2 port disabled", v, 8'h05);
    wrReg(2'd0, 8'h80);
    sendFrame(8, 9'h055, 1'b1, 16);
    rdReg(2'd3, v); check("R2 continuous off", v, 8'h05);
    wrReg(2'd0, 8'h90);
    wrReg(2'd3, 8'h07);
    sendFrame(8, 9'h055, 1'b1, 16);
    rdReg(2'd3, v); check("R2 sync mode", v, 8'h07);
    wrReg(2'd3, 8'h05);

    // R10 false start
    @(negedge clk); rxLine = 1'b0;
    repeat (4) @(negedge clk); rxLine = 1'b1;
    repeat (48) @(negedge clk);
    rdReg(2'd3, v); check("R10 glitch ignored", v, 8'h05);
    sendFrame(8, 9'h09D, 1'b1, 16);
    expectFrame("R10 next frame ok", 8'h90, 8'h9D);

    // R5 interrupt mask
    wrReg(2'd3, 8'h01);
    sendFrame(8, 9'h042, 1'b1, 16);
    check("R5 masked irq", rxIrq, 0);
    rdReg(2'd3, v); check("R5 ready while masked", v, 8'h81);
    wrReg(2'd3, 8'h05);
    check("R5 unmasked irq", rxIrq, 1);
    rdReg(2'd1, v); check("R5 masked data", v, 8'h42);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule